// File: doc/BRIEF.md
# Dual-Clock Four-Bit Mode Shift Register

This block is a four-stage register with a parallel data path and a serial data path. Two strobe inputs control it. The shift strobe moves the contents one stage towards the last stage and takes the serial bit into the first stage. The load strobe copies the four parallel inputs into the four stages. A single mode line selects which strobe has any effect. Each strobe acts only on its falling edge, and rising edges never act.

The whole block runs on one fast system clock. Both strobes and the mode line are sampled by that clock. A falling edge is seen when the stored previous sample of a strobe is 1 and the present sample is 0. The mode value used with an edge is the one present in that same cycle. The register has no separate left-shift operation. A left shift is made outside the block by wiring each output back to the parallel input of the stage before it, placing the serial bit on the last parallel input, and using load mode. Both strobes may be tied to one source. The mode line alone then picks a shift or a load on each falling edge.

There is no stream handshake. The data pins are plain levels, so there is no back-pressure: an output stays valid until the next qualifying edge replaces it.

Top module: `quad_mode_shreg`

## Requirements
- R1: When mode_i is 1 and a falling edge of ld_stb_i is seen, q_o takes the value of par_i on the next system clock edge. Bit i of par_i goes to bit i of q_o, where bit 0 is the first stage and bit 3 is the last.
- R2: During a load, ser_i has no effect on the value stored.
- R3: When mode_i is 0 and a falling edge of sh_stb_i is seen, the register shifts. The new q_o[0] is ser_i and the new q_o[k] is the old q_o[k-1] for k = 1, 2, 3.
- R4: A falling edge of ld_stb_i while mode_i is 0, and a falling edge of sh_stb_i while mode_i is 1, leave q_o unchanged.
- R5: A rising edge on either strobe never changes q_o.
- R6: With no qualifying edge, q_o holds its value, even when mode_i or the data inputs change.
- R7: With par_i driven as {ser_i, q_o[3:1]} outside the block and mode_i at 1, each load falling edge shifts the contents from the last stage towards the first, and ser_i enters q_o[3].
- R8: With one signal driving both strobes, each falling edge shifts when mode_i is 0 and loads when mode_i is 1.
- R9: A falling edge is seen in the system clock cycle in which a strobe samples 0 after having sampled 1 in the cycle before. The mode used is the one sampled in that cycle, and the result appears at the system clock edge that ends that cycle.
- R10: An active-low asynchronous reset clears q_o to 0 and sets both stored strobe samples to 0, so a strobe that is low when reset is released gives no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sh_stb_i | input | 1 | Shift strobe; acts on its falling edge when mode_i is 0 |
| ld_stb_i | input | 1 | Load strobe; acts on its falling edge when mode_i is 1 |
| mode_i | input | 1 | 0 selects shift, 1 selects load |
| ser_i | input | 1 | Serial bit for the first stage on a shift |
| par_i | input | 4 | Parallel load data; bit 0 is the first stage |
| q_o | output | 4 | Register contents; bit 0 is the first stage |

## Verification
The hardest case to create from the ports is the left shift. It exists only when the bench itself closes a loop from q_o back to par_i, so each load depends on the value the design has just produced. The bench builds that feedback as a continuous assignment and computes the expected left shift from its own model. Timing corners also take care: a strobe may fall in the same cycle that mode_i flips, and both strobes may be tied together. The stimulus drives these cases cycle by cycle, so the mode value that counts is always the one present in the edge cycle.

// File: rtl/qms_pkg.sv
package qms_pkg;
  typedef enum logic [1:0] {
    QMS_HOLD  = 2'd0,
    QMS_SHIFT = 2'd1,
    QMS_LOAD  = 2'd2
  } qms_op_e;
endpackage

// File: rtl/qms_fall_detect.sv
module qms_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic prev_o,
  output logic fall_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_o <= 1'b0;
    else        prev_o <= sig_i;
  end

  assign fall_o = prev_o & ~sig_i;

  // R10
  reset_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !prev_o);
endmodule

// File: rtl/qms_op_decode.sv
module qms_op_decode
  import qms_pkg::*;
(
  input  logic    sh_fall_i,
  input  logic    ld_fall_i,
  input  logic    mode_i,
  output qms_op_e op_o
);
  always_comb begin
    op_o = QMS_HOLD;
    if (mode_i) begin
      if (ld_fall_i) op_o = QMS_LOAD;
    end else begin
      if (sh_fall_i) op_o = QMS_SHIFT;
    end
  end
endmodule

// File: rtl/qms_stage_array.sv
module qms_stage_array
  import qms_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qms_op_e          op_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] shift_src;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign shift_src[k] = ser_i;
    end else begin : g_body
      assign shift_src[k] = q_o[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_o[k] <= 1'b0;
      end else begin
        case (op_i)
          QMS_SHIFT: q_o[k] <= shift_src[k];
          QMS_LOAD:  q_o[k] <= par_i[k];
          default:   q_o[k] <= q_o[k];
        endcase
      end
    end
  end

  // R3
  tail_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == QMS_SHIFT) |=> q_o[LAST] == $past(q_o[LAST-1]));
endmodule

// File: rtl/quad_mode_shreg.sv
module quad_mode_shreg
  import qms_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sh_stb_i,
  input  logic             ld_stb_i,
  input  logic             mode_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o
);
  logic    sh_prev, ld_prev;
  logic    sh_fall, ld_fall;
  qms_op_e op;

  qms_fall_detect u_sh_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(sh_stb_i), .prev_o(sh_prev), .fall_o(sh_fall)
  );

  qms_fall_detect u_ld_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(ld_stb_i), .prev_o(ld_prev), .fall_o(ld_fall)
  );

  qms_op_decode u_dec (
    .sh_fall_i(sh_fall), .ld_fall_i(ld_fall), .mode_i(mode_i), .op_o(op)
  );

  qms_stage_array #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .op_i(op), .ser_i(ser_i), .par_i(par_i), .q_o(q_o)
  );

  // R1
  load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && ld_prev && !ld_stb_i) |=> q_o == $past(par_i));

  // R3
  shift_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && sh_prev && !sh_stb_i) |=> q_o[0] == $past(ser_i));

  // R4
  wrong_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i && !(ld_prev && !ld_stb_i)) || (!mode_i && !(sh_prev && !sh_stb_i)))
      |=> $stable(q_o));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sh_prev && !sh_stb_i) && !(ld_prev && !ld_stb_i)) |=> $stable(q_o));
endmodule

// File: tb/quad_mode_shreg_tb_top.sv
module quad_mode_shreg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sh_stb = 1'b0, ld_stb = 1'b0, mode = 1'b0, ser = 1'b0;
  logic [3:0] par_drv = 4'h0;
  logic       wire_left = 1'b0;
  logic [3:0] par_bus;
  logic [3:0] q;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];
  logic [3:0] mdl_q = 4'h0;
  logic       mdl_p1 = 1'b0, mdl_p2 = 1'b0;

  always #10 clk = ~clk;

  assign par_bus = wire_left ? {ser, q[3:1]} : par_drv;

  quad_mode_shreg dut_i (
    .clk(clk), .rst_n(rst_n), .sh_stb_i(sh_stb), .ld_stb_i(ld_stb),
    .mode_i(mode), .ser_i(ser), .par_i(par_bus), .q_o(q)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: q_o=%b expected %b", tag, act, exp);
    end
  endtask

  // Driver: one system cycle per call; pushes the model result.
  task automatic step(input logic c1, input logic c2, input logic m,
                      input logic s, input logic [3:0] p, input string tag);
    logic f1, f2;
    @(negedge clk);
    sh_stb = c1; ld_stb = c2; mode = m; ser = s; par_drv = p;
    f1 = mdl_p1 & ~c1;
    f2 = mdl_p2 & ~c2;
    if (m && f2)       mdl_q = wire_left ? {s, mdl_q[3:1]} : p;
    else if (!m && f1) mdl_q = {mdl_q[2:0], s};
    mdl_p1 = c1; mdl_p2 = c2;
    exp_q.push_back(mdl_q);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares after each system edge.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) check(q, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: q_o=%b expected run end", q);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(q, 4'h0, "R10 reset value");
    @(negedge clk) rst_n = 1'b1;
    step(0, 0, 0, 1, 4'hF, "R10 no false edge");
    check(q, 4'h0, "R10 after release");
    // R1 / R2: load with serial high and low
    step(0, 1, 1, 1, 4'b1010, "R5 load rise");
    step(0, 0, 1, 1, 4'b1010, "R1 R2 load");
    step(0, 1, 1, 0, 4'b0110, "R5 load rise");
    step(0, 0, 1, 0, 4'b0110, "R1 R2 load");
    // R3: right shifts
    for (int i = 0; i < 6; i++) begin
      step(1, 0, 0, 1'(i % 3 != 1), 4'h0, "R5 shift rise");
      step(0, 0, 0, 1'(i % 3 != 1), 4'h0, "R3 shift");
    end
    // R4: wrong strobe ignored in each mode
    step(0, 1, 0, 1, 4'h9, "R4 ld rise mode0");
    step(0, 0, 0, 1, 4'h9, "R4 ld fall mode0");
    step(1, 0, 1, 0, 4'h5, "R4 sh rise mode1");
    step(0, 0, 1, 0, 4'h5, "R4 sh fall mode1");
    // R6: mode and data change with no edge
    for (int i = 0; i < 4; i++) step(0, 0, 1'(i), 1'(i >> 1), 4'(i * 5), "R6 idle");
    // R9: mode taken in the edge cycle
    step(1, 0, 1, 1, 4'h0, "R9 prep");
    step(0, 0, 0, 1, 4'h0, "R9 mode falls with edge");
    step(1, 0, 0, 0, 4'h0, "R9 prep");
    step(0, 0, 1, 0, 4'h0, "R9 mode rises with edge");
    step(0, 0, 0, 0, 4'h0, "R9 mode low after edge");
    // R7: left shift by feedback wiring
    step(0, 1, 1, 0, 4'b1101, "R5 load rise");
    step(0, 0, 1, 0, 4'b1101, "R1 seed");
    @(negedge clk) wire_left = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(0, 1, 1, 1'(i == 1 || i == 2), 4'h0, "R7 rise");
      step(0, 0, 1, 1'(i == 1 || i == 2), 4'h0, "R7 left shift");
    end
    @(negedge clk) wire_left = 1'b0;
    // R8: tied strobes
    for (int i = 0; i < 6; i++) begin
      step(1, 1, 1'(i % 2), 1'(i % 3 == 0), 4'(4'h3 + i), "R8 tied rise");
      step(0, 0, 1'(i % 2), 1'(i % 3 == 0), 4'(4'h3 + i), "R8 tied fall");
    end
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule